// File: doc/BRIEF.md
# Multi-Mode Per-Core Interrupt Timer

This block is a timer that sits beside one processor core and is reached through a small 32-bit register port. Software programs a start value, and the block counts it down at the bus clock rate divided by a power of two between 1 and 128. When the count runs out, the block emits an interrupt request that carries a vector number chosen by software. A two-bit mode field picks one of three behaviours:

- **Repeat:** the start value is reloaded and counting goes on.
- **Single:** the count stops at zero.
- **Deadline:** the down-counter is idle, and the block fires once a free-running timestamp reaches a programmed target.

Software reads the live count to measure elapsed ticks. A typical use is to calibrate the bus rate against another clock: load all-ones, wait a known interval, then read back how far the count has fallen. The same vector-entry register also holds a suppression flag. This flag silences the request line without halting the count.

Top module: `local_irq_timer`

## Requirements
- R1: In repeat mode (mode field bits 18:17 = 01), with start value N and divisor D, a request fires N*D cycles after the start-value write, and again every N*D cycles after that.
- R2: In single mode (mode field 00, or the unused code 11), exactly one request fires N*D cycles after the write. After that, the live count holds at zero.
- R3: The divisor is selected by bits {3,1,0} of the divider register (offset 0x3E0). Codes 000 to 110 select 2, 4, 8, 16, 32, 64 and 128, and code 111 selects 1. The divider phase restarts on every start-value write.
- R4: The live-count register (offset 0x390) returns the down-counter at any time. With divisor 1, it drops by one every clock after the write.
- R5: Writing a start value of zero stops the counter without any request, and the live count reads zero.
- R6: A start-value write while counting restarts the countdown from the new value.
- R7: While the suppression bit (bit 16 of the entry at 0x320) is set, no request leaves the block, but the counter keeps running. Clearing the bit restores requests.
- R8: In deadline mode (mode field 10), the 64-bit target is written as a low word (offset 0x3C0) and a high word (offset 0x3C4). A nonzero target arms the comparator. The request then fires in the cycle after the timestamp is greater than or equal to the target, and it fires only once per arming.
- R9: In deadline mode, start-value writes are ignored: the start-value register (offset 0x380) keeps its old value, the live count reads zero, and no count request fires.
- R10: The request is a one-cycle pulse. The vector output equals bits 7:0 of the entry during the pulse and is zero otherwise.
- R11: After reset, the request line is low, the entry reads 0x00010000 (suppressed, single mode, vector 0), and the divider and live count read zero.
- R12: The entry reads back its vector, suppression bit and mode field. The divider register reads back bits {3,1,0}, and the target words read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| stamp | input | 64 | Free-running timestamp for deadline mode |
| irq | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried by the request; zero when idle |

## Verification
The bench sweeps all eight divider codes and times the request to the exact cycle. A divider that is off by one, or a mis-decoded code, shows up as a wrong cycle count. It also checks the following:

- **Repeat and single modes:** the bench measures successive repeat intervals, and a design that reloads one tick late drifts from N*D. It also watches for a second request after a single-mode fire, which would expose a missing stop at zero.
- **Restart and zero writes:** a restart mid-count must time from the second write. A zero write must end in silence rather than a wrapped count.
- **Deadline mode:** the bench probes the exact boundary where the timestamp equals the target, uses a target that differs only in its high word, and requires that a sustained match fires only once. It also confirms that a start-value write in this mode leaves the stored start value and the live count untouched.

// File: rtl/lt_pkg.sv
package lt_pkg;
   localparam int unsigned ADDR_W = 12;

   localparam logic [ADDR_W-1:0] OFS_ENTRY = 12'h320;
   localparam logic [ADDR_W-1:0] OFS_START = 12'h380;
   localparam logic [ADDR_W-1:0] OFS_LIVE  = 12'h390;
   localparam logic [ADDR_W-1:0] OFS_TGTLO = 12'h3C0;
   localparam logic [ADDR_W-1:0] OFS_TGTHI = 12'h3C4;
   localparam logic [ADDR_W-1:0] OFS_DIV   = 12'h3E0;

   localparam int unsigned SUPP_BIT = 16;
   localparam int unsigned MODE_LSB = 17;

   typedef enum logic [1:0] {
      MODE_SINGLE   = 2'b00,
      MODE_REPEAT   = 2'b01,
      MODE_DEADLINE = 2'b10,
      MODE_SPARE    = 2'b11
   } tmode_e;

   // divider code {b3,b1,b0} -> log2 of divisor
   function automatic logic [2:0] div_shift(input logic [2:0] code);
      return (code == 3'b111) ? 3'd0 : code + 3'd1;
   endfunction
endpackage

// File: rtl/lt_prescale.sv
module lt_prescale #(
   parameter int unsigned MAX_SHIFT = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic [2:0] shift,
   output logic       tick
);
   localparam int unsigned CW = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

   if (MAX_SHIFT < 1 || MAX_SHIFT > 7) begin : g_bad_shift
      $error("lt_prescale: MAX_SHIFT must lie in 1..7");
   end

   logic [CW-1:0] phase_q;
   logic [CW:0]   span;
   logic [CW-1:0] limit;

   always_comb begin
      span  = (CW+1)'(1) << shift;
      limit = CW'(span - (CW+1)'(1));
   end

   assign tick = (phase_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)       phase_q <= '0;
      else if (restart) phase_q <= '0;
      else if (tick)    phase_q <= '0;
      else              phase_q <= phase_q + CW'(1);
   end

   // R3: with divisor 1 every cycle is a tick
   assert_div1_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (shift == 3'd0) |-> tick);
endmodule

// File: rtl/lt_downcnt.sv
module lt_downcnt #(
   parameter int unsigned CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          repeat_en,
   input  logic          halt,
   output logic [CW-1:0] live,
   output logic [CW-1:0] base,
   output logic          fire
);
   logic [CW-1:0] cur_q, base_q;
   logic          run_q;

   assign live = cur_q;
   assign base = base_q;
   assign fire = tick && run_q && !load && !halt && (cur_q == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q  <= '0;
         base_q <= '0;
         run_q  <= 1'b0;
      end else if (halt) begin
         cur_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         base_q <= load_val;
         cur_q  <= load_val;
         run_q  <= (load_val != '0);
      end else if (tick && run_q) begin
         if (cur_q == CW'(1)) begin
            if (repeat_en) cur_q <= base_q;
            else begin
               cur_q <= '0;
               run_q <= 1'b0;
            end
         end else begin
            cur_q <= cur_q - CW'(1);
         end
      end
   end

   assert_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && repeat_en) |=> (cur_q == $past(base_q)));
   assert_single_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !repeat_en) |=> (cur_q == '0 && !run_q));
   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run_q && !load && !halt && cur_q > CW'(1)) |=> (cur_q == $past(cur_q) - CW'(1)));
   assert_zero_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !halt && load_val == '0) |=> (!run_q && cur_q == '0));
   assert_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> (cur_q == '0 && !run_q));
endmodule

// File: rtl/lt_deadline.sv
module lt_deadline #(
   parameter int unsigned DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_lo,
   input  logic            wr_hi,
   input  logic [DW-1:0]   wdata,
   input  logic            enable,
   input  logic [2*DW-1:0] stamp,
   output logic [2*DW-1:0] target,
   output logic            fire
);
   logic [2*DW-1:0] tgt_q, tgt_nxt;
   logic            armed_q;

   always_comb begin
      tgt_nxt = tgt_q;
      if (wr_lo) tgt_nxt[DW-1:0]    = wdata;
      if (wr_hi) tgt_nxt[2*DW-1:DW] = wdata;
   end

   assign target = tgt_q;
   assign fire   = armed_q && enable && (stamp >= tgt_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q   <= '0;
         armed_q <= 1'b0;
      end else if (wr_lo || wr_hi) begin
         tgt_q   <= tgt_nxt;
         armed_q <= (tgt_nxt != '0);
      end else if (fire) begin
         armed_q <= 1'b0;
      end
   end

   assert_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !wr_lo && !wr_hi) |=> !armed_q);
endmodule

// File: rtl/local_irq_timer.sv
module local_irq_timer
   import lt_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned MAX_SHIFT   = 7,
   parameter bit          DEADLINE_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [2*DATA_W-1:0] stamp,
   output logic                irq,
   output logic [VEC_W-1:0]    irq_vector
);
   localparam int unsigned TS_W = 2 * DATA_W;

   if (DATA_W < 20) begin : g_bad_width
      $error("local_irq_timer: DATA_W must be at least 20");
   end
   if (VEC_W < 1 || VEC_W > SUPP_BIT) begin : g_bad_vec
      $error("local_irq_timer: VEC_W must lie in 1..16");
   end

   logic [VEC_W-1:0] vec_q;
   logic             supp_q;
   tmode_e           mode_q;
   logic [2:0]       div_q;

   logic wr_entry, wr_start, wr_div, wr_tlo, wr_thi;
   logic in_deadline, tick, cnt_fire, dl_fire, any_fire;
   logic [DATA_W-1:0] live, base;
   logic [TS_W-1:0]   target;

   assign in_deadline = (mode_q == MODE_DEADLINE);
   assign wr_entry = reg_wr && (reg_addr == OFS_ENTRY);
   assign wr_start = reg_wr && (reg_addr == OFS_START) && !in_deadline;
   assign wr_div   = reg_wr && (reg_addr == OFS_DIV);
   assign wr_tlo   = reg_wr && (reg_addr == OFS_TGTLO);
   assign wr_thi   = reg_wr && (reg_addr == OFS_TGTHI);

   wire unused_wbits = &{1'b0, reg_wdata[DATA_W-1:MODE_LSB+2],
                         reg_wdata[SUPP_BIT-1:VEC_W], reg_wdata[2]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q  <= '0;
         supp_q <= 1'b1;
         mode_q <= MODE_SINGLE;
         div_q  <= '0;
      end else begin
         if (wr_entry) begin
            vec_q  <= reg_wdata[VEC_W-1:0];
            supp_q <= reg_wdata[SUPP_BIT];
            mode_q <= tmode_e'(reg_wdata[MODE_LSB+1:MODE_LSB]);
         end
         if (wr_div) div_q <= {reg_wdata[3], reg_wdata[1:0]};
      end
   end

   lt_prescale #(.MAX_SHIFT(MAX_SHIFT)) u_prescale (
      .clk(clk), .rst_n(rst_n), .restart(wr_start),
      .shift(div_shift(div_q)), .tick(tick)
   );

   lt_downcnt #(.CW(DATA_W)) u_downcnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(wr_start),
      .load_val(reg_wdata), .repeat_en(mode_q == MODE_REPEAT),
      .halt(in_deadline), .live(live), .base(base), .fire(cnt_fire)
   );

   if (DEADLINE_EN) begin : g_deadline
      lt_deadline #(.DW(DATA_W)) u_deadline (
         .clk(clk), .rst_n(rst_n), .wr_lo(wr_tlo), .wr_hi(wr_thi),
         .wdata(reg_wdata), .enable(in_deadline), .stamp(stamp),
         .target(target), .fire(dl_fire)
      );
   end else begin : g_no_deadline
      wire unused_stamp = &{1'b0, stamp, wr_tlo, wr_thi};
      assign target  = '0;
      assign dl_fire = 1'b0;
   end

   assign any_fire = cnt_fire || dl_fire;

   logic             irq_q;
   logic [VEC_W-1:0] irq_vec_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q     <= 1'b0;
         irq_vec_q <= '0;
      end else begin
         irq_q     <= any_fire && !supp_q;
         irq_vec_q <= (any_fire && !supp_q) ? vec_q : '0;
      end
   end

   assign irq        = irq_q;
   assign irq_vector = irq_vec_q;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_ENTRY: begin
            reg_rdata[VEC_W-1:0]               = vec_q;
            reg_rdata[SUPP_BIT]                = supp_q;
            reg_rdata[MODE_LSB+1:MODE_LSB]     = mode_q;
         end
         OFS_START: reg_rdata = base;
         OFS_LIVE:  reg_rdata = in_deadline ? '0 : live;
         OFS_DIV:   begin
            reg_rdata[3]   = div_q[2];
            reg_rdata[1:0] = div_q[1:0];
         end
         OFS_TGTLO: reg_rdata = target[DATA_W-1:0];
         OFS_TGTHI: reg_rdata = target[TS_W-1:DATA_W];
         default:   reg_rdata = '0;
      endcase
   end

   assert_supp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      supp_q |=> !irq_q);
   assert_vec_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_q |-> (irq_vec_q == '0));
   assert_no_count_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_deadline |-> !cnt_fire);
endmodule

// File: tb/test_local_irq_timer.sv
`timescale 1ns/1ps
module test_local_irq_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] stamp = '0;
   logic        irq;
   logic [7:0]  irq_vector;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   local_irq_timer i_local_irq_timer (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stamp(stamp),
      .irq(irq), .irq_vector(irq_vector)
   );

   localparam logic [11:0] A_ENTRY = 12'h320, A_START = 12'h380, A_LIVE = 12'h390,
                           A_TLO = 12'h3C0, A_THI = 12'h3C4, A_DIV = 12'h3E0;
   localparam int NONE = 100000;

   task automatic check(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // cycles until irq is seen, or NONE
   task automatic wait_irq(input int limit, output int cnt, output logic [7:0] vec);
      cnt = NONE; vec = '0;
      for (int i = 1; i <= limit; i++) begin
         @(posedge clk); #1;
         if (irq) begin cnt = i; vec = irq_vector; break; end
      end
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [7:0]  vec;
      int          c;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11 reset state
      check("R11 irq", irq, 0);
      check("R11 vector", irq_vector, 0);
      rd(A_ENTRY, v); check("R11 entry", v, 32'h0001_0000);
      rd(A_DIV, v);   check("R11 divider", v, 0);
      rd(A_LIVE, v);  check("R11 live", v, 0);

      // R3 / R2 / R10 sweep over all divider codes, single mode, N=3
      for (int code = 0; code < 8; code++) begin
         int d;
         d = (code == 7) ? 1 : (2 << code);
         wr(A_DIV, {28'd0, code[2], 1'b0, code[1:0]});
         wr(A_ENTRY, 32'h40 + code);
         wr(A_START, 32'd3);
         wait_irq(3 * d + 5, c, vec);
         check($sformatf("R3 period code %0d", code), c, 3 * d);
         check("R10 vector", vec, 8'h40 + code);
         @(posedge clk); #1;
         check("R10 pulse width", irq, 0);
         check("R10 vector idle", irq_vector, 0);
         wait_irq(3 * d + 5, c, vec);
         check("R2 no second request", c, NONE);
         rd(A_LIVE, v); check("R2 live held at zero", v, 0);
      end

      // R12 readback
      wr(A_DIV, 32'h0000_000B);
      rd(A_DIV, v); check("R12 divider readback", v, 32'hB);
      wr(A_ENTRY, 32'h0006_0012);
      rd(A_ENTRY, v); check("R12 entry readback", v, 32'h0006_0012);

      // R2: spare mode code 11 behaves as single
      wr(A_START, 32'd4);
      wait_irq(10, c, vec); check("R2 spare mode fires", c, 4);
      wait_irq(10, c, vec); check("R2 spare mode once", c, NONE);

      // R1 repeat mode, divisor 2, N=5
      wr(A_DIV, 32'h0);
      wr(A_ENTRY, 32'h0002_0055);
      wr(A_START, 32'd5);
      for (int k = 0; k < 3; k++) begin
         wait_irq(20, c, vec);
         check($sformatf("R1 interval %0d", k), c, 10);
         check("R1 vector", vec, 8'h55);
      end

      // R5 zero start value stops silently
      wr(A_START, 32'd0);
      wait_irq(40, c, vec); check("R5 no request", c, NONE);
      rd(A_LIVE, v); check("R5 live zero", v, 0);

      // R4 live count, divisor 1
      wr(A_DIV, 32'hB);
      wr(A_ENTRY, 32'h21);
      wr(A_START, 32'hFFFF_FFFF);
      repeat (10) @(posedge clk);
      rd(A_LIVE, v); check("R4 live after 10", v, 32'hFFFF_FFF5);
      repeat (5) @(posedge clk);
      rd(A_LIVE, v); check("R4 live after 15", v, 32'hFFFF_FFF0);

      // R6 restart mid-count
      wr(A_START, 32'd8);
      wait_irq(20, c, vec); check("R6 restart timing", c, 8);

      // R7 suppression
      wr(A_ENTRY, 32'h0001_0033);
      wr(A_START, 32'd4);
      wait_irq(20, c, vec); check("R7 suppressed", c, NONE);
      rd(A_LIVE, v); check("R7 counter ran", v, 0);
      wr(A_ENTRY, 32'h33);
      wr(A_START, 32'd4);
      wait_irq(20, c, vec); check("R7 restored", c, 4);

      // R9 deadline mode ignores start writes
      wr(A_ENTRY, 32'h0004_0077);
      wr(A_START, 32'd3);
      rd(A_START, v); check("R9 start unchanged", v, 4);
      rd(A_LIVE, v);  check("R9 live zero", v, 0);
      wait_irq(20, c, vec); check("R9 no count request", c, NONE);

      // R8 deadline compare
      @(negedge clk); stamp = 64'd100;
      wr(A_THI, 32'd0);
      wr(A_TLO, 32'd150);
      rd(A_TLO, v); check("R12 target low readback", v, 150);
      wait_irq(10, c, vec); check("R8 before target", c, NONE);
      @(negedge clk); stamp = 64'd149;
      wait_irq(10, c, vec); check("R8 one below", c, NONE);
      @(negedge clk); stamp = 64'd150;
      wait_irq(5, c, vec);
      check("R8 at target", c, 1);
      check("R8 vector", vec, 8'h77);
      wait_irq(10, c, vec); check("R8 fires once", c, NONE);
      wr(A_THI, 32'd1);
      rd(A_THI, v); check("R12 target high readback", v, 1);
      @(negedge clk); stamp = 64'd500;
      wait_irq(10, c, vec); check("R8 high word gate", c, NONE);
      @(negedge clk); stamp = 64'h1_0000_0096;
      wait_irq(5, c, vec); check("R8 high word match", c, 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule